// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a PLL has reached the frequency of its reference. It receives two tick streams in one system-clock domain. One tick marks each reference edge and one marks each feedback edge. Over a window of a fixed number of reference ticks it counts the feedback ticks. At the close of the window it subtracts the nominal count to form a signed error. It then updates a lock flag with two thresholds: a tight band that sets the flag and a wider band that clears it. Between the two bands the flag keeps its value. Both bands are symmetric about zero error.

With the default window of 32768 reference ticks and equal nominal rates, one count of error is about 30.5 ppm. The default set threshold of 9 counts gives roughly 300 ppm, and the default clear threshold of 33 counts gives roughly 1000 ppm. A window with no feedback ticks at all counts as a dead oscillator and clears the flag.

If the reference stops for a set number of system cycles, the flag drops and the window starts again. A one-cycle strobe marks each completed window, and the signed error of that window stays visible on an output. All pins are plain control and status signals. The block has no streaming data path, so it uses no valid/ready handshake and applies no back-pressure.

Top module: `freq_lock_detector`

## Requirements
- R1: A window closes in the cycle that carries the WIN_LEN-th reference tick counted from the last restart. In the next cycle `win_done_o` is high for exactly one cycle.
- R2: When a window closes, `err_o` takes the number of feedback ticks seen in that window minus WIN_LEN, as a two's-complement value. A feedback tick in the closing cycle is included. `err_o` holds this value until the next close.
- R3: At a window close with |error| <= SET_THR, `lock_o` is high from the next cycle.
- R4: At a window close with |error| > CLR_THR, `lock_o` is low from the next cycle. This applies for both signs of the error.
- R5: At a window close with SET_THR < |error| <= CLR_THR, `lock_o` keeps its previous value.
- R6: A window that closes with zero feedback ticks clears `lock_o`, whatever the thresholds are.
- R7: Both counts restart after every close, so each window's error depends only on the ticks inside it.
- R8: After TIMEOUT_MULT*WIN_LEN consecutive cycles with no reference tick, `lock_o` goes low and the partial window is discarded. Fewer idle cycles change nothing.
- R9: A synchronous active-high `rst` clears the counts and the watchdog, and forces `lock_o`, `win_done_o` and `err_o` to zero.
- R10: `lock_o` changes only after a window close, a reference timeout, or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle pulse per reference edge |
| fb_tick | input | 1 | One-cycle pulse per feedback edge |
| lock_o | output | 1 | Lock flag |
| win_done_o | output | 1 | One-cycle strobe after each completed window |
| err_o | output | ERR_W | Signed error of the last window, in counts |

## Verification
The assertions assume that each tick input is already a clean single-cycle pulse in the system-clock domain. They also assume that WIN_LEN is at least 2, so two window closes can never fall on adjacent cycles. The stimulus meets both conditions. It places reference ticks on every other cycle and at most one feedback tick per cycle. In the closing cycle a feedback tick may coincide with the reference tick, and the sweep covers that case.

The sweep uses a small window and runs every feedback count from zero to twice the window, first rising and then falling. This takes the flag across both thresholds from each side. The timeout is driven with idle stretches just below and just above the limit.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [1:0] {
    BAND_NEAR = 2'd0,
    BAND_MID  = 2'd1,
    BAND_FAR  = 2'd2
  } band_e;
endpackage

// File: rtl/fld_window_counter.sv
module fld_window_counter #(
  parameter int WIN_LEN = 32768,
  parameter int FB_W    = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ref_tick,
  input  logic            fb_tick,
  output logic            win_end,
  output logic [FB_W-1:0] fb_total
);
  localparam int REF_W = $clog2(WIN_LEN);
  localparam logic [FB_W-1:0] FB_MAX = '1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN_LEN - 1);

  logic [REF_W-1:0] ref_cnt;
  logic [FB_W-1:0]  fb_cnt;

  // feedback total including a tick in this cycle, saturating
  always_comb begin
    if (fb_cnt == FB_MAX) fb_total = FB_MAX;
    else                  fb_total = fb_cnt + FB_W'(fb_tick);
  end

  assign win_end = ref_tick && (ref_cnt == REF_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || win_end) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
      fb_cnt <= fb_total;
    end
  end

  AST_FB_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (!clr && !win_end) |=> (fb_cnt >= $past(fb_cnt)));  // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (win_end || clr) |=> (fb_cnt == '0));  // R7
endmodule

// File: rtl/fld_band_classifier.sv
module fld_band_classifier
  import fld_pkg::*;
#(
  parameter int WIN_LEN = 32768,
  parameter int FB_W    = 17,
  parameter int ERR_W   = 18,
  parameter int SET_THR = 9,
  parameter int CLR_THR = 33
) (
  input  logic                    [FB_W-1:0]  fb_total,
  output logic signed             [ERR_W-1:0] err,
  output band_e                               band
);
  logic [ERR_W-1:0] mag;

  assign err = $signed({1'b0, fb_total}) - $signed(ERR_W'(WIN_LEN));
  assign mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);

  always_comb begin
    if (fb_total == '0)                  band = BAND_FAR;
    else if (mag > ERR_W'(CLR_THR))      band = BAND_FAR;
    else if (mag <= ERR_W'(SET_THR))     band = BAND_NEAR;
    else                                 band = BAND_MID;
  end
endmodule

// File: rtl/fld_ref_watchdog.sv
module fld_ref_watchdog #(
  parameter int TIMEOUT_CYC = 131072
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  output logic timeout
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0] TO_LIM  = TO_W'(TIMEOUT_CYC);
  localparam logic [TO_W-1:0] TO_FIRE = TO_W'(TIMEOUT_CYC - 1);

  logic [TO_W-1:0] idle_cnt;

  assign timeout = !ref_tick && (idle_cnt == TO_FIRE);

  always_ff @(posedge clk) begin
    if (rst || ref_tick)        idle_cnt <= '0;
    else if (idle_cnt != TO_LIM) idle_cnt <= idle_cnt + 1'b1;
  end

  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);  // R8

  AST_TICK_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !timeout);  // R8
endmodule

// File: rtl/fld_lock_ctrl.sv
module fld_lock_ctrl
  import fld_pkg::*;
#(
  parameter int ERR_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    win_end,
  input  logic                    timeout,
  input  band_e                   band,
  input  logic signed [ERR_W-1:0] err,
  output logic                    lock,
  output logic                    done,
  output logic signed [ERR_W-1:0] err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock  <= 1'b0;
      done  <= 1'b0;
      err_q <= '0;
    end else begin
      done <= win_end;
      if (timeout) begin
        lock <= 1'b0;
      end else if (win_end) begin
        err_q <= err;
        case (band)
          BAND_NEAR: lock <= 1'b1;
          BAND_FAR:  lock <= 1'b0;
          default:   lock <= lock;
        endcase
      end
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!win_end && !timeout) |=> $stable(lock));  // R10

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (win_end && band == BAND_MID) |=> $stable(lock));  // R5

  AST_NEAR_SETS: assert property (@(posedge clk) disable iff (rst)
    (win_end && band == BAND_NEAR) |=> lock);  // R3

  AST_FAR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((win_end && band == BAND_FAR) || timeout) |=> !lock);  // R4

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    win_end |=> done);  // R1
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
  import fld_pkg::*;
#(
  parameter int WIN_LEN      = 32768,
  parameter int SET_THR      = 9,
  parameter int CLR_THR      = 33,
  parameter int TIMEOUT_MULT = 4,
  localparam int FB_W        = $clog2(2 * WIN_LEN) + 1,
  localparam int ERR_W       = FB_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_tick,
  input  logic                    fb_tick,
  output logic                    lock_o,
  output logic                    win_done_o,
  output logic signed [ERR_W-1:0] err_o
);
  localparam int TIMEOUT_CYC = TIMEOUT_MULT * WIN_LEN;

  logic                    win_end;
  logic                    timeout;
  logic [FB_W-1:0]         fb_total;
  logic signed [ERR_W-1:0] err_now;
  band_e                   band;

  fld_window_counter #(.WIN_LEN(WIN_LEN), .FB_W(FB_W)) u_win (
    .clk(clk), .rst(rst), .clr(timeout), .ref_tick(ref_tick),
    .fb_tick(fb_tick), .win_end(win_end), .fb_total(fb_total)
  );

  fld_band_classifier #(
    .WIN_LEN(WIN_LEN), .FB_W(FB_W), .ERR_W(ERR_W),
    .SET_THR(SET_THR), .CLR_THR(CLR_THR)
  ) u_cls (
    .fb_total(fb_total), .err(err_now), .band(band)
  );

  fld_ref_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdg (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .timeout(timeout)
  );

  fld_lock_ctrl #(.ERR_W(ERR_W)) u_lock (
    .clk(clk), .rst(rst), .win_end(win_end), .timeout(timeout),
    .band(band), .err(err_now), .lock(lock_o), .done(win_done_o),
    .err_q(err_o)
  );

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    win_done_o |=> !win_done_o);  // R1

  AST_DEAD_FB_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    (win_end && fb_total == '0) |=> !lock_o);  // R6

  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(err_o));  // R2
endmodule

// File: tb/freq_lock_detector_tb_top.sv
module freq_lock_detector_tb_top;
  localparam int WIN = 64;
  localparam int SET = 2;
  localparam int CLR = 5;
  localparam int TMUL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic fb_tick = 1'b0;
  logic lock_o, win_done_o;
  logic signed [8:0] err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_lock = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  freq_lock_detector #(.WIN_LEN(WIN), .SET_THR(SET), .CLR_THR(CLR),
                       .TIMEOUT_MULT(TMUL)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .lock_o(lock_o), .win_done_o(win_done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic f);
    ref_tick = r;
    fb_tick  = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  // full window: reference on odd cycles, nfb feedback ticks from cycle 0
  task automatic run_window(input int nfb);
    int e, m;
    for (int i = 0; i < 2 * WIN; i++) begin
      cyc(i % 2 == 1, i < nfb);
      if (i == 20) chk(win_done_o == 1'b0, "R1 no strobe mid-window", win_done_o, 0);
    end
    e = nfb - WIN;
    m = (e < 0) ? -e : e;
    if (nfb == 0)      exp_lock = 1'b0;      // R6
    else if (m > CLR)  exp_lock = 1'b0;      // R4
    else if (m <= SET) exp_lock = 1'b1;      // R3
    // else R5 hold
    chk(win_done_o == 1'b1, "R1 strobe at close", win_done_o, 1);
    chk(int'(err_o) == e, "R2 R7 window error", int'(err_o), e);
    chk(lock_o == exp_lock, "R3 R4 R5 R6 lock", lock_o, exp_lock);
    ref_tick = 1'b0;
    fb_tick  = 1'b0;
    cyc(1'b0, 1'b0);
    chk(win_done_o == 1'b0, "R1 strobe one cycle", win_done_o, 0);
    chk(lock_o == exp_lock, "R10 lock steady", lock_o, exp_lock);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lock_o == 1'b0, "R9 reset lock", lock_o, 0);
    chk(win_done_o == 1'b0, "R9 reset strobe", win_done_o, 0);
    chk(err_o == '0, "R9 reset err", int'(err_o), 0);
    rst = 1'b0;

    // rising then falling sweep over every feedback count
    for (int n = 0; n <= 2 * WIN; n++) run_window(n);
    for (int n = 2 * WIN; n >= 0; n--) run_window(n);

    // R8: idle below limit keeps lock, above limit clears it
    run_window(WIN);
    repeat (200) cyc(1'b0, 1'b0);
    chk(lock_o == 1'b1, "R8 short idle keeps lock", lock_o, 1);
    repeat (100) cyc(1'b0, 1'b0);
    exp_lock = 1'b0;
    chk(lock_o == 1'b0, "R8 timeout clears lock", lock_o, 0);

    // R8: partial window discarded by timeout
    run_window(WIN);
    for (int i = 0; i < 20; i++) cyc(i % 2 == 1, 1'b1);
    repeat (300) cyc(1'b0, 1'b0);
    chk(lock_o == 1'b0, "R8 timeout after partial", lock_o, 0);
    run_window(WIN);

    // R9: reset mid-window clears lock and counts
    for (int i = 0; i < 30; i++) cyc(i % 2 == 1, 1'b1);
    rst = 1'b1;
    cyc(1'b0, 1'b0);
    rst = 1'b0;
    exp_lock = 1'b0;
    chk(lock_o == 1'b0, "R9 reset drops lock", lock_o, 0);
    chk(err_o == '0, "R9 reset clears err", int'(err_o), 0);
    run_window(WIN + 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule